// File: doc/BRIEF.md
# Instruction Bundle Slot Decoder

This block takes fixed-size 128-bit instruction bundles and turns each into a short stream of per-slot operations for the issue logic behind it. A bundle holds a 5-bit template code in its lowest bits and three 41-bit instruction slots above it. The template code says which execution unit each slot targets and where the instruction-group boundaries ("stops") fall. The decoder attaches to every emitted operation its unit type, an end-of-group flag and a start-of-group flag.

Bundles enter through a valid/ready handshake. Operations leave, one per cycle, through a second valid/ready handshake in slot order. A new bundle is taken only once the last operation of the current one has been accepted downstream. The long-immediate template is special: its second and third slots form one 82-bit operation. A reserved template code produces one operation marked illegal and no slot operations.

Top module: `bundle_slot_decoder`

## Requirements
- R1: For an ordinary slot operation, `out_payload` holds slot k of the bundle, zero-extended to 82 bits. Slot 0 is bundle bits 45..5, slot 1 is bits 86..46 and slot 2 is bits 127..87. `out_slot` gives k.
- R2: A non-reserved, non-long template gives exactly three operations, in the order slot 0, 1, 2. `out_unit` uses the encoding memory=0, integer=1, floating=2, branch=3, long=4, none=7. For the template pairs (even code, and the code one above it) the slot units for slots 0,1,2 are: 0x00 M,I,I; 0x02 M,I,I; 0x08 M,M,I; 0x0A M,M,I; 0x0C M,F,I; 0x0E M,M,F; 0x10 M,I,B; 0x12 M,B,B; 0x16 B,B,B; 0x18 M,M,B; 0x1C M,F,B.
- R3: `out_stop` marks an operation after which a group ends. It is set after slot 2 exactly when template bit 0 is 1. It is set after slot 1 for templates 0x02 and 0x03, and after slot 0 for templates 0x0A and 0x0B. It is clear everywhere else.
- R4: Templates 0x04 and 0x05 give two operations. The first is slot 0 with unit memory. The second has `out_wide`=1, `out_slot`=1, unit long (4), payload equal to bundle bits 127..46, and `out_stop` equal to template bit 0.
- R5: Templates 0x06, 0x07, 0x14, 0x15, 0x1A, 0x1B, 0x1E and 0x1F give a single operation. It has `out_illegal`=1, a zero payload, unit none (7), and `out_stop`, `out_start` and `out_wide` all 0.
- R6: `out_start` is 1 on the first non-illegal operation after reset. On every later non-illegal operation it equals `out_stop` of the previous non-illegal operation. Illegal operations leave this tracking unchanged.
- R7: `in_ready` is 1 exactly when no operation is pending. A bundle is taken on `in_valid && in_ready`, and `in_valid` is ignored while `in_ready` is 0. The first operation is presented in the cycle after acceptance. After the last operation is accepted, `out_valid` drops and `in_ready` returns to 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R9: Synchronous reset clears any pending operation (`out_valid`=0, `in_ready`=1) and re-arms the start-of-group flag for the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Decoder can take a bundle |
| in_bundle | input | 128 | Template plus three slots |
| out_valid | output | 1 | Operation presented |
| out_ready | input | 1 | Downstream takes the operation |
| out_payload | output | 82 | Slot bits, or both upper slots for the long form |
| out_unit | output | 3 | Execution unit code |
| out_slot | output | 2 | Index of the first slot the operation occupies |
| out_stop | output | 1 | Group ends after this operation |
| out_start | output | 1 | Operation begins a group |
| out_wide | output | 1 | Operation is the combined long form |
| out_illegal | output | 1 | Bundle had a reserved template |

## Verification
Every one of the 32 template codes is fed in twice. The slot payloads are derived from a seed, so a swapped or shifted slot field shows up as a payload mismatch rather than a coincidental match. One pass keeps `out_ready` high, which checks the back-to-back ordering and the unit and stop tables. The other pass stalls every operation and offers a second bundle during the stall, which separates correct holding and input blocking from designs that only work without backpressure. A reset issued while a bundle is still pending, with a group left open, shows whether the start-of-group flag is re-armed.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int TMPL_W    = 5;
  localparam int UNIT_W    = 3;
  localparam int IDX_W     = 2;

  localparam logic [UNIT_W-1:0] UNIT_MEM  = 3'd0;
  localparam logic [UNIT_W-1:0] UNIT_INT  = 3'd1;
  localparam logic [UNIT_W-1:0] UNIT_FP   = 3'd2;
  localparam logic [UNIT_W-1:0] UNIT_BR   = 3'd3;
  localparam logic [UNIT_W-1:0] UNIT_LX   = 3'd4;
  localparam logic [UNIT_W-1:0] UNIT_NONE = 3'd7;

  typedef enum logic [1:0] {
    BK_PLAIN = 2'd0,
    BK_LONG  = 2'd1,
    BK_RSVD  = 2'd2
  } bkind_e;

  typedef struct packed {
    logic [NUM_SLOTS-1:0][UNIT_W-1:0] unit;
    logic [NUM_SLOTS-1:0]             stop;
    bkind_e                           kind;
  } tmpl_info_t;
endpackage

// File: rtl/bdec_template_rom.sv
module bdec_template_rom
  import bdec_pkg::*;
(
  input  logic [TMPL_W-1:0] tmpl,
  output tmpl_info_t        info
);
  localparam int PAIR_W = TMPL_W - 1;

  logic [PAIR_W-1:0] pair;
  assign pair = tmpl[TMPL_W-1:1];

  function automatic logic [NUM_SLOTS-1:0][UNIT_W-1:0] trio(
    input logic [UNIT_W-1:0] u0,
    input logic [UNIT_W-1:0] u1,
    input logic [UNIT_W-1:0] u2
  );
    return {u2, u1, u0};
  endfunction

  always_comb begin
    info.kind    = BK_PLAIN;
    info.unit    = trio(UNIT_NONE, UNIT_NONE, UNIT_NONE);
    info.stop    = '0;
    info.stop[2] = tmpl[0];
    case (pair)
      4'd0:  info.unit = trio(UNIT_MEM, UNIT_INT, UNIT_INT);
      4'd1: begin
        info.unit    = trio(UNIT_MEM, UNIT_INT, UNIT_INT);
        info.stop[1] = 1'b1;
      end
      4'd2: begin
        info.unit = trio(UNIT_MEM, UNIT_LX, UNIT_LX);
        info.kind = BK_LONG;
      end
      4'd4:  info.unit = trio(UNIT_MEM, UNIT_MEM, UNIT_INT);
      4'd5: begin
        info.unit    = trio(UNIT_MEM, UNIT_MEM, UNIT_INT);
        info.stop[0] = 1'b1;
      end
      4'd6:  info.unit = trio(UNIT_MEM, UNIT_FP,  UNIT_INT);
      4'd7:  info.unit = trio(UNIT_MEM, UNIT_MEM, UNIT_FP);
      4'd8:  info.unit = trio(UNIT_MEM, UNIT_INT, UNIT_BR);
      4'd9:  info.unit = trio(UNIT_MEM, UNIT_BR,  UNIT_BR);
      4'd11: info.unit = trio(UNIT_BR,  UNIT_BR,  UNIT_BR);
      4'd12: info.unit = trio(UNIT_MEM, UNIT_MEM, UNIT_BR);
      4'd14: info.unit = trio(UNIT_MEM, UNIT_FP,  UNIT_BR);
      default: begin
        info.kind = BK_RSVD;
        info.stop = '0;
      end
    endcase
  end
endmodule

// File: rtl/bdec_slot_extract.sv
module bdec_slot_extract
  import bdec_pkg::*;
#(
  parameter int SLOT_W = 41
) (
  input  logic [TMPL_W+NUM_SLOTS*SLOT_W-1:0] bundle,
  output logic [TMPL_W-1:0]                  tmpl,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]   slots
);
  assign tmpl = bundle[TMPL_W-1:0];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slots[k] = bundle[TMPL_W + k*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/bdec_beat_seq.sv
module bdec_beat_seq
  import bdec_pkg::*;
#(
  parameter int SLOT_W = 41,
  parameter int PAY_W  = 2 * SLOT_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] ld_slots,
  input  tmpl_info_t                      ld_info,
  input  logic                            out_ready,
  output logic                            out_valid,
  output logic [PAY_W-1:0]                out_payload,
  output logic [UNIT_W-1:0]               out_unit,
  output logic [IDX_W-1:0]                out_slot,
  output logic                            out_stop,
  output logic                            out_start,
  output logic                            out_wide,
  output logic                            out_illegal
);
  typedef struct packed {
    logic [PAY_W-1:0]  pay;
    logic [UNIT_W-1:0] unit;
    logic [IDX_W-1:0]  slot;
    logic              stop;
    logic              wide;
    logic              illegal;
  } beat_t;

  function automatic beat_t build_beat(
    input logic [IDX_W-1:0]                idx,
    input logic [NUM_SLOTS-1:0][SLOT_W-1:0] s,
    input tmpl_info_t                      inf
  );
    beat_t b;
    b = '0;
    if (inf.kind == BK_RSVD) begin
      b.unit    = UNIT_NONE;
      b.illegal = 1'b1;
    end else if (inf.kind == BK_LONG && idx != '0) begin
      b.pay  = {s[2], s[1]};
      b.unit = UNIT_LX;
      b.stop = inf.stop[2];
      b.wide = 1'b1;
      b.slot = IDX_W'(1);
    end else begin
      case (idx)
        2'd0:    b.pay = {{(PAY_W-SLOT_W){1'b0}}, s[0]};
        2'd1:    b.pay = {{(PAY_W-SLOT_W){1'b0}}, s[1]};
        default: b.pay = {{(PAY_W-SLOT_W){1'b0}}, s[2]};
      endcase
      case (idx)
        2'd0:    b.unit = inf.unit[0];
        2'd1:    b.unit = inf.unit[1];
        default: b.unit = inf.unit[2];
      endcase
      case (idx)
        2'd0:    b.stop = inf.stop[0];
        2'd1:    b.stop = inf.stop[1];
        default: b.stop = inf.stop[2];
      endcase
      b.slot = idx;
    end
    return b;
  endfunction

  function automatic logic final_beat(input logic [IDX_W-1:0] idx, input bkind_e kind);
    case (kind)
      BK_RSVD: return 1'b1;
      BK_LONG: return idx == IDX_W'(1);
      default: return idx == IDX_W'(NUM_SLOTS-1);
    endcase
  endfunction

  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slots_q;
  tmpl_info_t                       info_q;
  logic [IDX_W-1:0]                 idx_q;
  logic                             pend_start_q;
  beat_t                            first_b;
  beat_t                            next_b;
  logic                             take;
  logic                             last_now;

  assign take     = out_valid && out_ready;
  assign last_now = final_beat(idx_q, info_q.kind);

  always_comb begin
    first_b = build_beat('0, ld_slots, ld_info);
    next_b  = build_beat(idx_q + IDX_W'(1), slots_q, info_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_q      <= '0;
      info_q       <= '{unit: '0, stop: '0, kind: BK_PLAIN};
      idx_q        <= '0;
      pend_start_q <= 1'b1;
      out_valid    <= 1'b0;
      out_payload  <= '0;
      out_unit     <= UNIT_NONE;
      out_slot     <= '0;
      out_stop     <= 1'b0;
      out_start    <= 1'b0;
      out_wide     <= 1'b0;
      out_illegal  <= 1'b0;
    end else begin
      if (take) begin
        if (!out_illegal) pend_start_q <= out_stop;
        if (last_now) begin
          out_valid <= 1'b0;
        end else begin
          idx_q       <= idx_q + IDX_W'(1);
          out_payload <= next_b.pay;
          out_unit    <= next_b.unit;
          out_slot    <= next_b.slot;
          out_stop    <= next_b.stop;
          out_wide    <= next_b.wide;
          out_illegal <= next_b.illegal;
          out_start   <= out_stop;
        end
      end
      if (load) begin
        slots_q     <= ld_slots;
        info_q      <= ld_info;
        idx_q       <= '0;
        out_valid   <= 1'b1;
        out_payload <= first_b.pay;
        out_unit    <= first_b.unit;
        out_slot    <= first_b.slot;
        out_stop    <= first_b.stop;
        out_wide    <= first_b.wide;
        out_illegal <= first_b.illegal;
        out_start   <= first_b.illegal ? 1'b0 : pend_start_q;
      end
    end
  end
endmodule

// File: rtl/bundle_slot_decoder.sv
module bundle_slot_decoder
  import bdec_pkg::*;
#(
  parameter int SLOT_W = 41
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [TMPL_W+NUM_SLOTS*SLOT_W-1:0]    in_bundle,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic [2*SLOT_W-1:0]                   out_payload,
  output logic [UNIT_W-1:0]                     out_unit,
  output logic [IDX_W-1:0]                      out_slot,
  output logic                                  out_stop,
  output logic                                  out_start,
  output logic                                  out_wide,
  output logic                                  out_illegal
);
  localparam int PAY_W = 2 * SLOT_W;

  logic [TMPL_W-1:0]                tmpl;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slots;
  tmpl_info_t                       info;
  logic                             accept;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  bdec_slot_extract #(.SLOT_W(SLOT_W)) u_extract (
    .bundle (in_bundle),
    .tmpl   (tmpl),
    .slots  (slots)
  );

  bdec_template_rom u_rom (
    .tmpl (tmpl),
    .info (info)
  );

  bdec_beat_seq #(.SLOT_W(SLOT_W), .PAY_W(PAY_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .ld_slots    (slots),
    .ld_info     (info),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_payload (out_payload),
    .out_unit    (out_unit),
    .out_slot    (out_slot),
    .out_stop    (out_stop),
    .out_start   (out_start),
    .out_wide    (out_wide),
    .out_illegal (out_illegal)
  );
endmodule

// File: rtl/bdec_checker.sv
module bdec_checker
  import bdec_pkg::*;
#(
  parameter int SLOT_W = 41
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*SLOT_W-1:0] out_payload,
  input logic [UNIT_W-1:0]   out_unit,
  input logic [IDX_W-1:0]    out_slot,
  input logic                out_stop,
  input logic                out_start,
  input logic                out_wide,
  input logic                out_illegal
);
  logic is_last;
  assign is_last = out_illegal || out_wide || (out_slot == IDX_W'(NUM_SLOTS-1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_unit)
      && $stable(out_slot) && $stable(out_stop) && $stable(out_start)
      && $stable(out_wide) && $stable(out_illegal));

  assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && !in_ready);

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && is_last |=> !out_valid && in_ready);

  assert_order0_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_illegal && out_slot == '0 |=> out_valid && out_slot == IDX_W'(1));

  assert_order1_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_illegal && !out_wide && out_slot == IDX_W'(1)
      |=> out_valid && out_slot == IDX_W'(2) && !out_wide);

  assert_illegal_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_unit == UNIT_NONE && out_payload == '0
      && !out_stop && !out_start && !out_wide);

  assert_wide_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_wide |-> out_unit == UNIT_LX && out_slot == IDX_W'(1));

  assert_start_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_illegal && !is_last |=> out_start == $past(out_stop));

  assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready);
endmodule

bind bundle_slot_decoder bdec_checker #(.SLOT_W(SLOT_W)) u_checker (.*);

// File: tb/tb_bundle_slot_decoder.sv
`timescale 1ns/1ps
module tb_bundle_slot_decoder;
  localparam int SW = 41;
  localparam int PW = 2 * SW;
  localparam int BW = 5 + 3 * SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_bundle = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_payload;
  logic [2:0]    out_unit;
  logic [1:0]    out_slot;
  logic          out_stop, out_start, out_wide, out_illegal;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;
  bit pend   = 1;

  always #2 clk = ~clk;

  bundle_slot_decoder #(.SLOT_W(SW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
    .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
    .out_unit(out_unit), .out_slot(out_slot), .out_stop(out_stop), .out_start(out_start),
    .out_wide(out_wide), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] mk_slot(input int s, input int k);
    return {9'(s * 3 + k), 32'(s) * 32'h9E3779B9 + 32'(k) * 32'h7F4A7C15};
  endfunction

  // units for slots 0,1,2 packed as {u2,u1,u0}; M=0 I=1 F=2 B=3 LX=4
  function automatic logic [8:0] unit_trio(input logic [4:0] t);
    logic [2:0] u0, u1, u2;
    u0 = 3'd7; u1 = 3'd7; u2 = 3'd7;
    case (t[4:1])
      4'd0, 4'd1: begin u0 = 0; u1 = 1; u2 = 1; end
      4'd2:       begin u0 = 0; u1 = 4; u2 = 4; end
      4'd4, 4'd5: begin u0 = 0; u1 = 0; u2 = 1; end
      4'd6:       begin u0 = 0; u1 = 2; u2 = 1; end
      4'd7:       begin u0 = 0; u1 = 0; u2 = 2; end
      4'd8:       begin u0 = 0; u1 = 1; u2 = 3; end
      4'd9:       begin u0 = 0; u1 = 3; u2 = 3; end
      4'd11:      begin u0 = 3; u1 = 3; u2 = 3; end
      4'd12:      begin u0 = 0; u1 = 0; u2 = 3; end
      4'd14:      begin u0 = 0; u1 = 2; u2 = 3; end
      default: ;
    endcase
    return {u2, u1, u0};
  endfunction

  task automatic run_bundle(input logic [4:0] t, input int seed, input bit stall);
    logic [SW-1:0] s [3];
    logic [BW-1:0] b;
    logic [8:0]    ut;
    logic [2:0]    st;
    bit            rsvd, longf;
    int            nb;
    logic [PW-1:0] e_pay;
    logic [2:0]    e_unit;
    logic [1:0]    e_slot;
    logic          e_stop, e_wide, e_ill, e_start;
    for (int k = 0; k < 3; k++) s[k] = mk_slot(seed, k);
    b     = {s[2], s[1], s[0], t};
    ut    = unit_trio(t);
    rsvd  = (t[4:1] == 4'd3) || (t[4:1] == 4'd10) || (t[4:1] == 4'd13) || (t[4:1] == 4'd15);
    longf = (t[4:1] == 4'd2);
    st    = rsvd ? 3'b000 : {t[0], t[4:1] == 4'd1, t[4:1] == 4'd5};
    nb    = rsvd ? 1 : (longf ? 2 : 3);

    while (!in_ready) @(negedge clk);
    check($sformatf("R7 idle ready t=%0h", t), {127'b0, in_ready}, 128'd1);
    in_valid  = 1'b1;
    in_bundle = b;
    @(negedge clk);
    in_valid  = 1'b0;
    in_bundle = ~b;

    for (int k = 0; k < nb; k++) begin
      if (rsvd) begin
        e_pay = '0; e_unit = 3'd7; e_stop = 0; e_wide = 0; e_slot = 0; e_ill = 1; e_start = 0;
      end else if (longf && k == 1) begin
        e_pay = {s[2], s[1]}; e_unit = 3'd4; e_stop = st[2]; e_wide = 1; e_slot = 1; e_ill = 0;
        e_start = pend;
      end else begin
        e_pay = {{SW{1'b0}}, s[k]}; e_unit = ut[k*3 +: 3]; e_stop = st[k]; e_wide = 0;
        e_slot = 2'(k); e_ill = 0; e_start = pend;
      end
      if (stall) begin
        out_ready = 1'b0;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        check($sformatf("R7 blocked while busy t=%0h beat=%0d", t, k), {127'b0, in_ready}, 128'd0);
      end
      check($sformatf("R7 R8 valid t=%0h beat=%0d", t, k), {127'b0, out_valid}, 128'd1);
      check($sformatf("R1 R4 payload t=%0h beat=%0d", t, k), 128'(out_payload), 128'(e_pay));
      check($sformatf("R2 unit t=%0h beat=%0d", t, k), 128'(out_unit), 128'(e_unit));
      check($sformatf("R2 slot t=%0h beat=%0d", t, k), 128'(out_slot), 128'(e_slot));
      check($sformatf("R3 stop t=%0h beat=%0d", t, k), 128'(out_stop), 128'(e_stop));
      check($sformatf("R4 wide t=%0h beat=%0d", t, k), 128'(out_wide), 128'(e_wide));
      check($sformatf("R5 illegal t=%0h beat=%0d", t, k), 128'(out_illegal), 128'(e_ill));
      check($sformatf("R6 start t=%0h beat=%0d", t, k), 128'(out_start), 128'(e_start));
      if (!e_ill) pend = e_stop;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    check($sformatf("R7 released t=%0h", t), {126'b0, out_valid, in_ready}, 128'b01);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset valid", {127'b0, out_valid}, 128'd0);
    check("R9 reset ready", {127'b0, in_ready}, 128'd1);

    for (int t = 0; t < 32; t++) run_bundle(5'(t), t + 1, 1'b0);
    for (int t = 31; t >= 0; t--) run_bundle(5'(t), t + 77, 1'b1);

    // leave a group open, then reset with a bundle pending
    run_bundle(5'h00, 500, 1'b0);
    in_valid  = 1'b1;
    in_bundle = {mk_slot(9, 2), mk_slot(9, 1), mk_slot(9, 0), 5'h08};
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 mid-run reset valid", {127'b0, out_valid}, 128'd0);
    check("R9 mid-run reset ready", {127'b0, in_ready}, 128'd1);
    pend = 1;
    run_bundle(5'h00, 600, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule